// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, day of week, day of month, month and two-digit year. A prescaler counts system clock cycles down to a one-second tick. On each tick the seconds field advances, and carries ripple upward through minutes, hours, day, month and year. The hours field can use a 24-hour encoding or a 12-hour encoding with a PM flag. A century flag in the month field flips each time the year wraps.

Software or a bus bridge loads any field through a single-cycle write port that takes a 3-bit field selector. Writing the seconds field also restarts the sub-second count, so the next tick comes exactly one second after that write. A square-wave output at 1 Hz can be enabled. It is low for the first half of each second and high for the second half, so after a seconds write it rises half a second later. Illegal written values never stall the counters, but the sequence that follows them is not defined.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. A step from 59 returns the field to 00 and advances the next field up.
- R2: With hours bit 6 at 0 (24-hour), bits 5:0 hold BCD 00 to 23. A step from 23 gives 00 and advances the day.
- R3: With hours bit 6 at 1 (12-hour), bit 5 is the PM flag (1 = PM) and bits 4:0 hold BCD 1 to 12. 11 steps to 12 and inverts PM, and 12 steps to 1. The day advances only on the step from 11 PM to 12 AM.
- R4: Day of week advances once per day advance and steps 1, 2, …, 7, 1.
- R5: The date returns to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 for February, or 29 when the binary value of the year is a multiple of 4. Month 12 wraps to 01 and advances the year.
- R6: Month bit 7 is the century flag. It inverts whenever the year steps from 99 to 00, and month bits 4:0 hold BCD 01 to 12.
- R7: `tick_o` pulses for one cycle every TICKS_PER_SEC cycles. The fields advance on the clock edge that ends the pulse and hold otherwise unless written.
- R8: A write with `wr_en` high loads `wr_data` into the field chosen by `wr_sel` at the next edge. The selector codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year.
- R9: A seconds write restarts the prescaler. The next `tick_o` is seen TICKS_PER_SEC-1 cycles after the write edge, and the seconds advance TICKS_PER_SEC cycles after it.
- R10: With `sqw_en` high, `sqw_o` is high while the sub-second count is at or above TICKS_PER_SEC/2, so it rises TICKS_PER_SEC/2 cycles after a seconds write. With `sqw_en` low, it is low from the next edge on.
- R11: A write in a tick cycle to a field other than seconds stores the written value in that field. All other fields still advance from their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 8 | Packed BCD value to load |
| sqw_en | input | 1 | Enables the 1 Hz square wave |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode and PM/tens bits |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Century flag and month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| tick_o | output | 1 | One-cycle pulse ahead of each one-second advance |
| sqw_o | output | 1 | 1 Hz square wave |

## Verification
The bench builds the block with TICKS_PER_SEC set to 8. One simulated second then lasts eight cycles, so the bench can run through minute, midnight, month-end, leap-year and century rollovers in a few thousand cycles. The half-second point falls on cycle 4, which lets the bench see the exact cycle on which the square wave rises after a seconds write and the exact cycle of the following tick. The small period also lets the bench land a write precisely on a tick cycle to test how a write and an advance interact.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef logic [7:0] bcd8_t;

    typedef enum logic [2:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_DOW   = 3'd3,
        SEL_DATE  = 3'd4,
        SEL_MONTH = 3'd5,
        SEL_YEAR  = 3'd6,
        SEL_NONE  = 3'd7
    } field_sel_e;

    localparam int HOUR_MODE_BIT = 6;
    localparam int HOUR_PM_BIT   = 5;
    localparam int CENTURY_BIT   = 7;

    typedef struct packed {
        bcd8_t sec;
        bcd8_t min;
        bcd8_t hour;
    } clock_t;

    typedef struct packed {
        bcd8_t dow;
        bcd8_t date;
        bcd8_t month;
        bcd8_t year;
    } cal_t;

    typedef struct packed {
        logic  carry;
        bcd8_t value;
    } step_t;

    localparam clock_t CLOCK_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00};
    localparam cal_t   CAL_RESET   = '{dow: 8'h01, date: 8'h01, month: 8'h01, year: 8'h00};

    // Add one in packed BCD; a units digit of 9 or more rolls into the tens digit.
    function automatic bcd8_t bcd_inc(bcd8_t v);
        bcd8_t r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    // Step a BCD field: at or above the top value it restarts at first and carries.
    function automatic step_t bcd_wrap_inc(bcd8_t v, bcd8_t top, bcd8_t first);
        step_t r;
        if (v >= top) begin
            r.carry = 1'b1;
            r.value = first;
        end else begin
            r.carry = 1'b0;
            r.value = bcd_inc(v);
        end
        return r;
    endfunction

    // Advance the hours field in whichever encoding bit 6 selects.
    function automatic step_t hour_step(bcd8_t h);
        step_t r;
        bcd8_t v;
        bcd8_t n;
        logic  pm;
        pm = h[HOUR_PM_BIT];
        if (h[HOUR_MODE_BIT]) begin
            v = {3'b000, h[4:0]};
            if (v >= 8'h12) begin
                r.carry = 1'b0;
                r.value = {1'b0, 1'b1, pm, 5'h01};
            end else if (v == 8'h11) begin
                r.carry = pm;
                r.value = {1'b0, 1'b1, ~pm, 5'h12};
            end else begin
                n = bcd_inc(v);
                r.carry = 1'b0;
                r.value = {1'b0, 1'b1, pm, n[4:0]};
            end
        end else begin
            v = {2'b00, h[5:0]};
            if (v >= 8'h23) begin
                r.carry = 1'b1;
                r.value = 8'h00;
            end else begin
                r.carry = 1'b0;
                r.value = bcd_inc(v);
            end
        end
        return r;
    endfunction

    // Last day of a month in BCD; leap years are years whose binary value divides by 4.
    function automatic bcd8_t month_len(bcd8_t mon, bcd8_t yr);
        logic [6:0] ybin;
        bcd8_t      r;
        ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        case (mon[4:0])
            5'h02:                      r = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic sqw_en,
    output logic tick,
    output logic sqw
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] HALF = CW'(TICKS_PER_SEC / 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          sqw_q;

    always_comb begin
        tick = (cnt_q == LAST) && !restart;
        if (restart || (cnt_q == LAST)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sqw_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            sqw_q <= sqw_en && (cnt_d >= HALF);
        end
    end

    assign sqw = sqw_q;

endmodule

// File: rtl/rtc_cal_clock.sv
module rtc_cal_clock
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_en,
    input  field_sel_e wr_sel,
    input  bcd8_t      wr_data,
    output clock_t     time_q,
    output logic       day_adv
);
    clock_t q;
    clock_t nxt;
    step_t  s_st;
    step_t  m_st;
    step_t  h_st;

    always_comb begin
        s_st = bcd_wrap_inc(q.sec, 8'h59, 8'h00);
        m_st = bcd_wrap_inc(q.min, 8'h59, 8'h00);
        h_st = hour_step(q.hour);
        nxt  = q;
        if (tick) begin
            nxt.sec = s_st.value;
            if (s_st.carry) begin
                nxt.min = m_st.value;
                if (m_st.carry) begin
                    nxt.hour = h_st.value;
                end
            end
        end
        if (wr_en) begin
            case (wr_sel)
                SEL_SEC:  nxt.sec  = wr_data;
                SEL_MIN:  nxt.min  = wr_data;
                SEL_HOUR: nxt.hour = wr_data;
                default:  ;
            endcase
        end
        day_adv = tick && s_st.carry && m_st.carry && h_st.carry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CLOCK_RESET;
        end else begin
            q <= nxt;
        end
    end

    assign time_q = q;

endmodule

// File: rtl/rtc_cal_calendar.sv
module rtc_cal_calendar
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       day_adv,
    input  logic       wr_en,
    input  field_sel_e wr_sel,
    input  bcd8_t      wr_data,
    output cal_t       cal_q
);
    cal_t  q;
    cal_t  nxt;
    bcd8_t last_day;
    step_t w_st;
    step_t d_st;
    step_t m_st;
    step_t y_st;

    always_comb begin
        last_day = month_len(q.month, q.year);
        w_st = bcd_wrap_inc(q.dow, 8'h07, 8'h01);
        d_st = bcd_wrap_inc(q.date, last_day, 8'h01);
        m_st = bcd_wrap_inc({3'b000, q.month[4:0]}, 8'h12, 8'h01);
        y_st = bcd_wrap_inc(q.year, 8'h99, 8'h00);
        nxt  = q;
        if (day_adv) begin
            nxt.dow  = w_st.value;
            nxt.date = d_st.value;
            if (d_st.carry) begin
                nxt.month = {q.month[CENTURY_BIT], q.month[6:5], m_st.value[4:0]};
                if (m_st.carry) begin
                    nxt.year = y_st.value;
                    if (y_st.carry) begin
                        nxt.month[CENTURY_BIT] = ~q.month[CENTURY_BIT];
                    end
                end
            end
        end
        if (wr_en) begin
            case (wr_sel)
                SEL_DOW:   nxt.dow   = wr_data;
                SEL_DATE:  nxt.date  = wr_data;
                SEL_MONTH: nxt.month = wr_data;
                SEL_YEAR:  nxt.year  = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CAL_RESET;
        end else begin
            q <= nxt;
        end
    end

    assign cal_q = q;

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       sqw_en,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       tick_o,
    output logic       sqw_o
);
    field_sel_e sel;
    logic       restart;
    logic       tick;
    logic       day_adv;
    clock_t     time_q;
    cal_t       cal_q;

    assign sel     = field_sel_e'(wr_sel);
    assign restart = wr_en && (sel == SEL_SEC);

    rtc_cal_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_prescaler (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .sqw_en  (sqw_en),
        .tick    (tick),
        .sqw     (sqw_o)
    );

    rtc_cal_clock u_clock (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (wr_data),
        .time_q  (time_q),
        .day_adv (day_adv)
    );

    rtc_cal_calendar u_calendar (
        .clk     (clk),
        .rst     (rst),
        .day_adv (day_adv),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (wr_data),
        .cal_q   (cal_q)
    );

    assign sec_o   = time_q.sec;
    assign min_o   = time_q.min;
    assign hour_o  = time_q.hour;
    assign dow_o   = cal_q.dow;
    assign date_o  = cal_q.date;
    assign month_o = cal_q.month;
    assign year_o  = cal_q.year;
    assign tick_o  = tick;

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk #(
    parameter int TICKS_PER_SEC = 32768
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       sqw_en,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic       tick_o,
    input logic       sqw_o
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;

    logic [CW-1:0] since;
    logic          sec_wr;

    assign sec_wr = wr_en && (wr_sel == 3'd0);

    // Cycles since the last tick or seconds write, counted from the ports.
    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
        end else if (sec_wr || tick_o) begin
            since <= '0;
        end else begin
            since <= since + 1'b1;
        end
    end

    assert_tick_period_R7: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (since == CW'(TICKS_PER_SEC - 1)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!tick_o && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(date_o)));

    assert_sec_load_R8: assert property (@(posedge clk) disable iff (rst)
        sec_wr |=> (sec_o == $past(wr_data)));

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        sec_wr |=> !tick_o);

    assert_sqw_off_R10: assert property (@(posedge clk) disable iff (rst)
        !sqw_en |=> !sqw_o);

    assert_century_R6: assert property (@(posedge clk) disable iff (rst)
        ((month_o[7] != $past(month_o[7])) && !$past(wr_en)) |-> (($past(year_o) == 8'h99) && (year_o == 8'h00)));

endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(
    .TICKS_PER_SEC(TICKS_PER_SEC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .sqw_en  (sqw_en),
    .sec_o   (sec_o),
    .min_o   (min_o),
    .hour_o  (hour_o),
    .date_o  (date_o),
    .month_o (month_o),
    .year_o  (year_o),
    .tick_o  (tick_o),
    .sqw_o   (sqw_o)
);

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
    localparam int TPS  = 8;
    localparam int HALF = TPS / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       sqw_en = 1'b0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
    logic       tick_o, sqw_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Behavioural reference state (plain integers).
    int  m_cnt, m_sec, m_min, m_h24, m_dow, m_date, m_mon, m_year;
    bit  m_mode12, m_cent;

    always #2 clk = ~clk;

    rtc_calendar_core #(.TICKS_PER_SEC(TPS)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sqw_en(sqw_en), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .tick_o(tick_o), .sqw_o(sqw_o)
    );

    function automatic int to_bcd(int n);
        return (n / 10) * 16 + (n % 10);
    endfunction

    function automatic int from_bcd(int b);
        return (b / 16) * 10 + (b % 16);
    endfunction

    function automatic int days_of(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int enc_hour();
        int v;
        if (!m_mode12) return to_bcd(m_h24);
        v = m_h24 % 12;
        if (v == 0) v = 12;
        return 64 + ((m_h24 >= 12) ? 32 : 0) + to_bcd(v);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_sec = 0; m_min = 0; m_h24 = 0; m_mode12 = 1'b0;
        m_dow = 1; m_date = 1; m_mon = 1; m_year = 0; m_cent = 1'b0;
    endtask

    task automatic model_edge();
        bit sw;
        bit adv;
        int v;
        sw  = wr_en && (wr_sel == 3'd0);
        adv = (m_cnt == TPS - 1) && !sw;
        m_cnt = (sw || m_cnt == TPS - 1) ? 0 : m_cnt + 1;
        if (adv) begin
            m_sec++;
            if (m_sec == 60) begin
                m_sec = 0; m_min++;
                if (m_min == 60) begin
                    m_min = 0; m_h24++;
                    if (m_h24 == 24) begin
                        m_h24 = 0;
                        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                        m_date++;
                        if (m_date > days_of(m_mon, m_year)) begin
                            m_date = 1; m_mon++;
                            if (m_mon == 13) begin
                                m_mon = 1; m_year++;
                                if (m_year == 100) begin
                                    m_year = 0; m_cent = ~m_cent;
                                end
                            end
                        end
                    end
                end
            end
        end
        if (wr_en) begin
            case (wr_sel)
                3'd0: m_sec = from_bcd(int'(wr_data));
                3'd1: m_min = from_bcd(int'(wr_data));
                3'd2: begin
                    m_mode12 = wr_data[6];
                    if (wr_data[6]) begin
                        v = from_bcd(int'(wr_data[4:0]));
                        m_h24 = ((v == 12) ? 0 : v) + (wr_data[5] ? 12 : 0);
                    end else begin
                        m_h24 = from_bcd(int'(wr_data[5:0]));
                    end
                end
                3'd3: m_dow = from_bcd(int'(wr_data));
                3'd4: m_date = from_bcd(int'(wr_data));
                3'd5: begin
                    m_cent = wr_data[7];
                    m_mon  = from_bcd(int'(wr_data[4:0]));
                end
                3'd6: m_year = from_bcd(int'(wr_data));
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        bit sw;
        sw = wr_en && (wr_sel == 3'd0);
        chk("R1 seconds", int'(sec_o), to_bcd(m_sec));
        chk("R1 minutes", int'(min_o), to_bcd(m_min));
        chk(m_mode12 ? "R3 hours" : "R2 hours", int'(hour_o), enc_hour());
        chk("R4 day of week", int'(dow_o), to_bcd(m_dow));
        chk("R5 date", int'(date_o), to_bcd(m_date));
        chk("R6 month", int'(month_o), (m_cent ? 128 : 0) + to_bcd(m_mon));
        chk("R5 year", int'(year_o), to_bcd(m_year));
        chk("R7 tick", int'(tick_o), int'((m_cnt == TPS - 1) && !sw));
        chk("R10 square wave", int'(sqw_o), int'(sqw_en && (m_cnt >= HALF)));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                           input logic [7:0] yr);
        wr(3'd0, s); wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dw);
        wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int k_sqw;
        int k_tick;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all();                         // reset state, R7 tick low

        // R1: roll seconds into minutes over 70 seconds
        run(70 * TPS);

        // R8: a seconds load shows up at the next edge
        wr(3'd0, 8'h42);
        chk("R8 seconds load", int'(sec_o), 8'h42);

        // R2: 24-hour midnight, R4 day of week 7 to 1
        set_all(8'h55, 8'h59, 8'h23, 8'h07, 8'h10, 8'h06, 8'h21);
        run(8 * TPS);
        chk("R2 midnight hours", int'(hour_o), 8'h00);
        chk("R4 dow wrap", int'(dow_o), 8'h01);

        // R3: 12-hour, 11 AM to 12 PM, then 12 PM to 1 PM
        set_all(8'h55, 8'h59, 8'h51, 8'h02, 8'h05, 8'h03, 8'h22);
        run(8 * TPS);
        chk("R3 noon", int'(hour_o), 8'h72);
        wr(3'd1, 8'h59); wr(3'd0, 8'h58);
        run(4 * TPS);
        chk("R3 one pm", int'(hour_o), 8'h61);

        // R3: 11 PM to 12 AM advances the date
        set_all(8'h56, 8'h59, 8'h71, 8'h03, 8'h14, 8'h08, 8'h19);
        run(6 * TPS);
        chk("R3 midnight 12h", int'(hour_o), 8'h52);
        chk("R3 date step", int'(date_o), 8'h15);

        // R5: leap February, plain February, 30-day month
        set_all(8'h57, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
        run(5 * TPS);
        chk("R5 leap day", int'(date_o), 8'h29);
        set_all(8'h57, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
        run(5 * TPS);
        chk("R5 march first", int'(month_o), 8'h03);
        set_all(8'h57, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
        run(5 * TPS);
        chk("R5 may first", int'(month_o), 8'h05);

        // R6: year 99 to 00 with century flip, both directions
        set_all(8'h57, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        run(5 * TPS);
        chk("R6 century set", int'(month_o), 8'h81);
        chk("R6 year wrap", int'(year_o), 8'h00);
        set_all(8'h57, 8'h59, 8'h23, 8'h05, 8'h31, 8'h92, 8'h99);
        run(5 * TPS);
        chk("R6 century clear", int'(month_o), 8'h01);

        // R9 and R10: phase after a seconds write with the square wave on
        sqw_en = 1'b1;
        run(3);
        wr(3'd0, 8'h20);
        k_sqw = -1; k_tick = -1;
        for (int k = 1; k <= TPS + 2; k++) begin
            step();
            if (k_sqw < 0 && sqw_o) k_sqw = k;
            if (k_tick < 0 && tick_o) k_tick = k;
        end
        chk("R10 rise delay", k_sqw, HALF);
        chk("R9 tick delay", k_tick, TPS - 1);
        run(3 * TPS);
        sqw_en = 1'b0;
        run(2);
        chk("R10 disabled", int'(sqw_o), 0);

        // R11: minute write lands on a tick cycle
        wr(3'd0, 8'h10);
        run(TPS - 1);
        wr(3'd1, 8'h33);
        chk("R11 seconds advanced", int'(sec_o), 8'h11);
        chk("R11 minutes written", int'(min_o), 8'h33);
        run(2 * TPS);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule